// File: doc/BRIEF.md
# Peripheral Chip Select Generator

This block decodes bus addresses against a programmable base and drives six active-low peripheral chip selects, numbered 0 to 3, 5 and 6. There is no select 4. The base locates a 1 KB block. The block is placed either in the 20-bit memory space or in the 16-bit I/O space. The block is cut into eight 128-byte windows. Windows 0 to 3 feed selects 0 to 3, and windows 5 and 6 feed selects 5 and 6. Windows 4 and 7 drive nothing.

Two configuration registers set the block up, and they are written through a simple write port.
- The main register holds the base, the address space used by selects 0 to 3, a ready mode and a wait-state code.
- The auxiliary register sets the space, ready mode and wait count for selects 5 and 6. It can also turn those two pins into address outputs that carry address bits 2 and 1.

No select asserts until both registers have been written since reset. For every decoded bus cycle, the block counts the programmed wait states before it raises ready towards the bus unit. Depending on the ready mode, it may also wait for the external ready input.

Top module: `pcs_gen`

## Requirements
- R1: After reset, cs_n_o is 4'hF, cs_a2_o and cs_a1_o are 1, and rdy_o is 0.
- R2: No select asserts until both registers have been written. Register 0 is written with cfg_sel_i=0 and register 1 with cfg_sel_i=1. If only register 0 has been written, an address in the block produces no select.
- R3: Memory decode works as follows.
  - Register 0 bits [15:6] are compared with address bits [19:10].
  - Address bits [9:7] pick the window: windows 0..3 drive cs_n_o[0..3], window 5 drives cs_a2_o low, and window 6 drives cs_a1_o low.
  - Windows 4 and 7, and addresses outside the block, drive nothing.
- R4: When register 0 bit 5 is 1, selects 0..3 respond only to I/O cycles (io_cyc_i=1). In that case, address bits [15:10] are compared with register 0 bits [11:6], and address bits [19:16] are ignored. When bit 5 is 0, selects 0..3 respond only to memory cycles.
- R5: Register 1 bit 1 picks the space for selects 5 and 6 (1 = I/O, 0 = memory), independently of register 0 bit 5.
- R6: Register 0 bits [2:0] give the wait count for selects 0..3: codes 0..7 map to 0, 1, 2, 3, 5, 7, 9 and 15 cycles. The select asserts on the first clock edge that samples strobe_i high. rdy_o goes high after that many further edges, or in the same cycle when the count is 0.
- R7: Register 1 bits [4:3] give 0 to 3 wait states for selects 5 and 6, timed as in R6.
- R8: Register 0 bit 3 sets the ready mode for selects 0..3, and register 1 bit 2 sets it for selects 5 and 6.
  - When the mode bit is 0, ext_rdy_i is ignored.
  - When the mode bit is 1, rdy_o is high only when the count has expired and ext_rdy_i is high, and it follows ext_rdy_i in the same cycle.
- R9: When register 1 bit 0 is 1, cs_a2_o carries addr_i[2] and cs_a1_o carries addr_i[1] combinationally, and windows 5 and 6 raise no select or ready.
- R10: The address is captured on the edge that starts the cycle. While strobe_i stays high, address changes do not move the select. All selects deassert on the first edge that samples strobe_i low.
- R11: rdy_o stays low during a bus cycle that hits no select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 20 | Bus address |
| io_cyc_i | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| strobe_i | input | 1 | High for the duration of a bus cycle |
| ext_rdy_i | input | 1 | External ready |
| cfg_we_i | input | 1 | Register write enable |
| cfg_sel_i | input | 1 | Register select: 0 = main, 1 = auxiliary |
| cfg_wdata_i | input | 16 | Register write data |
| cs_n_o | output | 4 | Active-low selects 0..3 |
| cs_a2_o | output | 1 | Select 5 (active low) or address bit 2 |
| cs_a1_o | output | 1 | Select 6 (active low) or address bit 1 |
| rdy_o | output | 1 | Ready to the bus unit |

## Verification
Each result has its own due time:
- The selects are registered, so they are due one edge after strobe_i is first sampled high.
- The wait count makes rdy_o due exactly N edges after that.
- Release is due one edge after strobe_i is sampled low.
- In ext-ready mode, rdy_o follows ext_rdy_i within the same cycle, and the address-output pins follow addr_i with no clock at all.

The bench drives every input on the falling edge and samples one time unit after each rising edge. It counts edges from select assertion to rdy_o and compares that count with the value the wait code implies. For the combinational paths it samples one time unit after the falling edge that changed the input.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int ADDR_W    = 20;
  localparam int IO_ADDR_W = 16;
  localparam int WIN_BITS  = 7;
  localparam int NUM_WIN   = 8;
  localparam int LO_SELS   = 4;
  localparam int WIN_A2    = 5;
  localparam int WIN_A1    = 6;
  localparam int IDX_W     = $clog2(NUM_WIN);
  localparam int BLK_BITS  = WIN_BITS + IDX_W;
  localparam int BASE_W    = ADDR_W - BLK_BITS;
  localparam int IO_CMP_W  = IO_ADDR_W - BLK_BITS;
  localparam int DATA_W    = 16;
  localparam int CNT_W     = 4;
  localparam int LO_CODE_W = 3;
  localparam int HI_WAIT_W = 2;

  // register 0 layout
  localparam int LO_CODE_LSB  = 0;
  localparam int LO_RDY_BIT   = 3;
  localparam int LO_SPARE_BIT = 4;
  localparam int LO_IO_BIT    = 5;
  // register 1 layout
  localparam int HI_PIN_BIT   = 0;
  localparam int HI_IO_BIT    = 1;
  localparam int HI_RDY_BIT   = 2;
  localparam int HI_WAIT_LSB  = 3;

  typedef struct packed {
    logic [BASE_W-1:0]    base;
    logic                 io;
    logic                 rdy_ext;
    logic [LO_CODE_W-1:0] wcode;
  } lo_cfg_t;

  typedef struct packed {
    logic                 pin_addr;
    logic                 io;
    logic                 rdy_ext;
    logic [HI_WAIT_W-1:0] waits;
  } hi_cfg_t;

  function automatic logic [CNT_W-1:0] lo_waits(input logic [LO_CODE_W-1:0] code);
    case (code)
      3'd4:    return CNT_W'(5);
      3'd5:    return CNT_W'(7);
      3'd6:    return CNT_W'(9);
      3'd7:    return CNT_W'(15);
      default: return CNT_W'(code);
    endcase
  endfunction
endpackage

// File: rtl/pcs_cfg_regs.sv
module pcs_cfg_regs
  import pcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output lo_cfg_t           lo_cfg_o,
  output hi_cfg_t           hi_cfg_o,
  output logic              armed_o
);
  lo_cfg_t lo_q;
  hi_cfg_t hi_q;
  logic    lo_wr_q, hi_wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      hi_q    <= '0;
      lo_wr_q <= 1'b0;
      hi_wr_q <= 1'b0;
    end else if (we_i) begin
      if (sel_i) begin
        hi_q.pin_addr <= wdata_i[HI_PIN_BIT];
        hi_q.io       <= wdata_i[HI_IO_BIT];
        hi_q.rdy_ext  <= wdata_i[HI_RDY_BIT];
        hi_q.waits    <= wdata_i[HI_WAIT_LSB +: HI_WAIT_W];
        hi_wr_q       <= 1'b1;
      end else begin
        lo_q.base    <= wdata_i[DATA_W-1 -: BASE_W];
        lo_q.io      <= wdata_i[LO_IO_BIT];
        lo_q.rdy_ext <= wdata_i[LO_RDY_BIT];
        lo_q.wcode   <= wdata_i[LO_CODE_LSB +: LO_CODE_W];
        lo_wr_q      <= 1'b1;
      end
    end
  end

  assign lo_cfg_o = lo_q;
  assign hi_cfg_o = hi_q;
  assign armed_o  = lo_wr_q & hi_wr_q;

  logic unused_bits;
  assign unused_bits = ^{wdata_i[LO_SPARE_BIT], wdata_i[DATA_W-1:HI_WAIT_LSB+HI_WAIT_W]};

  // R2: once armed, stays armed until reset
  a_r2_arm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |=> armed_o);
endmodule

// File: rtl/pcs_decode.sv
module pcs_decode
  import pcs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_cyc_i,
  input  logic              armed_i,
  input  lo_cfg_t           lo_cfg_i,
  input  hi_cfg_t           hi_cfg_i,
  output logic [NUM_WIN-1:0] hit_o,
  output logic [CNT_W-1:0]  waits_o,
  output logic              rdy_ext_o
);
  logic [IDX_W-1:0] idx;
  logic mem_match, io_match, space_match_lo, space_match_hi, blk_lo, blk_hi, lo_any;

  assign idx       = addr_i[WIN_BITS +: IDX_W];
  assign mem_match = addr_i[ADDR_W-1 -: BASE_W] == lo_cfg_i.base;
  // I/O space: only the low IO_ADDR_W bits of the address take part
  assign io_match  = addr_i[IO_ADDR_W-1 -: IO_CMP_W] == lo_cfg_i.base[IO_CMP_W-1:0];

  assign space_match_lo = (io_cyc_i == lo_cfg_i.io) && (io_cyc_i ? io_match : mem_match);
  assign space_match_hi = (io_cyc_i == hi_cfg_i.io) && (io_cyc_i ? io_match : mem_match);
  assign blk_lo = armed_i && space_match_lo;
  assign blk_hi = armed_i && !hi_cfg_i.pin_addr && space_match_hi;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    if (w < LO_SELS) begin : g_lo
      assign hit_o[w] = blk_lo && (idx == IDX_W'(w));
    end else if (w == WIN_A2 || w == WIN_A1) begin : g_hi
      assign hit_o[w] = blk_hi && (idx == IDX_W'(w));
    end else begin : g_none
      assign hit_o[w] = 1'b0;
    end
  end

  assign lo_any    = |hit_o[LO_SELS-1:0];
  assign waits_o   = lo_any ? lo_waits(lo_cfg_i.wcode) : CNT_W'(hi_cfg_i.waits);
  assign rdy_ext_o = lo_any ? lo_cfg_i.rdy_ext : hi_cfg_i.rdy_ext;

  logic unused_addr;
  assign unused_addr = ^addr_i[WIN_BITS-1:0];
endmodule

// File: rtl/pcs_cycle_trk.sv
module pcs_cycle_trk
  import pcs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strobe_i,
  input  logic               ext_rdy_i,
  input  logic [NUM_WIN-1:0] hit_i,
  input  logic [CNT_W-1:0]   waits_i,
  input  logic               rdy_ext_i,
  output logic [NUM_WIN-1:0] sel_o,
  output logic               rdy_o
);
  logic               strobe_q, act_q, rdy_ext_q, start;
  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_WIN-1:0] sel_q;

  assign start = strobe_i & ~strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q  <= 1'b0;
      act_q     <= 1'b0;
      rdy_ext_q <= 1'b0;
      cnt_q     <= '0;
      sel_q     <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (!strobe_i) begin
        act_q <= 1'b0;
        sel_q <= '0;
        cnt_q <= '0;
      end else if (start) begin
        act_q     <= |hit_i;
        sel_q     <= hit_i;
        cnt_q     <= waits_i;
        rdy_ext_q <= rdy_ext_i;
      end else if (act_q && cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign sel_o = sel_q;
  assign rdy_o = act_q && (cnt_q == '0) && (!rdy_ext_q || ext_rdy_i);

  // R10: select frozen for the rest of the strobe
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_q && strobe_i) |=> $stable(sel_q));
  // R10: release on the edge that sees strobe low
  a_r10_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> (sel_q == '0));
  // R6: wait counter steps down by one per cycle
  a_r6_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && strobe_q && strobe_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R11: ready only inside a decoded cycle
  a_r11_rdy_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> (|sel_q));
  // R3: at most one select at a time
  a_r3_one_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_q));
endmodule

// File: rtl/pcs_gen.sv
module pcs_gen
  import pcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_cyc_i,
  input  logic              strobe_i,
  input  logic              ext_rdy_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [LO_SELS-1:0] cs_n_o,
  output logic              cs_a2_o,
  output logic              cs_a1_o,
  output logic              rdy_o
);
  localparam int A2_BIT = 2;
  localparam int A1_BIT = 1;

  lo_cfg_t            lo_cfg;
  hi_cfg_t            hi_cfg;
  logic               armed, rdy_ext;
  logic [NUM_WIN-1:0] hit, sel;
  logic [CNT_W-1:0]   waits;

  pcs_cfg_regs u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .sel_i    (cfg_sel_i),
    .wdata_i  (cfg_wdata_i),
    .lo_cfg_o (lo_cfg),
    .hi_cfg_o (hi_cfg),
    .armed_o  (armed)
  );

  pcs_decode u_dec (
    .addr_i    (addr_i),
    .io_cyc_i  (io_cyc_i),
    .armed_i   (armed),
    .lo_cfg_i  (lo_cfg),
    .hi_cfg_i  (hi_cfg),
    .hit_o     (hit),
    .waits_o   (waits),
    .rdy_ext_o (rdy_ext)
  );

  pcs_cycle_trk u_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (strobe_i),
    .ext_rdy_i (ext_rdy_i),
    .hit_i     (hit),
    .waits_i   (waits),
    .rdy_ext_i (rdy_ext),
    .sel_o     (sel),
    .rdy_o     (rdy_o)
  );

  assign cs_n_o  = ~sel[LO_SELS-1:0];
  assign cs_a2_o = hi_cfg.pin_addr ? addr_i[A2_BIT] : ~sel[WIN_A2];
  assign cs_a1_o = hi_cfg.pin_addr ? addr_i[A1_BIT] : ~sel[WIN_A1];

  logic unused_sel;
  assign unused_sel = ^{sel[NUM_WIN-1], sel[LO_SELS]};

  // R2: nothing asserts before both registers are written
  a_r2_quiet_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |=> (&cs_n_o && (hi_cfg.pin_addr || (cs_a2_o && cs_a1_o))));
  // R9: address-output mode keeps windows 5/6 from ever being captured
  a_r9_no_hi_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_cfg.pin_addr && $stable(hi_cfg.pin_addr)) |=> !(sel[WIN_A2] || sel[WIN_A1]) || !$past(hi_cfg.pin_addr));
endmodule

// File: tb/pcs_gen_tb.sv
module pcs_gen_tb;
  localparam int CLK_P = 10;
  localparam int NORDY = 20;

  logic        clk_i = 0, rst_ni = 0;
  logic [19:0] addr_i = '0;
  logic        io_cyc_i = 0, strobe_i = 0, ext_rdy_i = 0;
  logic        cfg_we_i = 0, cfg_sel_i = 0;
  logic [15:0] cfg_wdata_i = '0;
  logic [3:0]  cs_n_o;
  logic        cs_a2_o, cs_a1_o, rdy_o;

  int checks = 0, errors = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  pcs_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .io_cyc_i(io_cyc_i),
    .strobe_i(strobe_i), .ext_rdy_i(ext_rdy_i), .cfg_we_i(cfg_we_i),
    .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i), .cs_n_o(cs_n_o),
    .cs_a2_o(cs_a2_o), .cs_a1_o(cs_a1_o), .rdy_o(rdy_o)
  );

  // hit: [3:0] selects 0..3, [4] unused, [5] select 5, [6] select 6
  typedef struct packed {
    logic [19:0] a;
    logic        io;
    logic [6:0]  hit;
    logic [4:0]  n;
  } vec_t;

  // base field 0x2A5 -> block at 0xA9400; reg0 wait code 5 (7 waits); reg1 waits 2
  localparam vec_t VECS [12] = '{
    '{20'hA9400, 1'b0, 7'h01, 5'd7},
    '{20'hA947F, 1'b0, 7'h01, 5'd7},
    '{20'hA9480, 1'b0, 7'h02, 5'd7},
    '{20'hA9500, 1'b0, 7'h04, 5'd7},
    '{20'hA95FF, 1'b0, 7'h08, 5'd7},
    '{20'hA9600, 1'b0, 7'h00, 5'd20},
    '{20'hA9680, 1'b0, 7'h20, 5'd2},
    '{20'hA9700, 1'b0, 7'h40, 5'd2},
    '{20'hA9780, 1'b0, 7'h00, 5'd20},
    '{20'hA9800, 1'b0, 7'h00, 5'd20},
    '{20'hA9000, 1'b0, 7'h00, 5'd20},
    '{20'hA9400, 1'b1, 7'h00, 5'd20}
  };

  localparam int LO_W [8] = '{0, 1, 2, 3, 5, 7, 9, 15};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic bus(input logic [19:0] a, input logic io,
                     output logic [6:0] hit, output int n, output logic [5:0] rel);
    @(negedge clk_i);
    addr_i = a; io_cyc_i = io; strobe_i = 1;
    @(posedge clk_i); #1;
    hit = {~cs_a1_o, ~cs_a2_o, 1'b0, ~cs_n_o};
    n = 0;
    while (!rdy_o && n < NORDY) begin
      @(posedge clk_i); #1;
      n++;
    end
    @(negedge clk_i);
    strobe_i = 0;
    @(posedge clk_i); #1;
    rel = {cs_a1_o, cs_a2_o, cs_n_o};
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] hit;
    logic [5:0] rel;
    int n;

    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1;
    repeat (2) @(posedge clk_i);
    #1;
    // R1 reset state
    chk(cs_n_o == 4'hF, "R1 cs_n", cs_n_o, 4'hF);
    chk(cs_a2_o && cs_a1_o, "R1 pins", {cs_a1_o, cs_a2_o}, 2'b11);
    chk(!rdy_o, "R1 rdy", rdy_o, 0);

    // R2 only register 0 written
    wr(1'b0, 16'hA945);
    bus(20'hA9400, 1'b0, hit, n, rel);
    chk(hit == 7'h00, "R2 unarmed", hit, 0);
    chk(n == NORDY, "R2 unarmed rdy", n, NORDY);

    // table walk: R3 decode, R8 ignore mode (ext_rdy low), R10 release, R11
    wr(1'b1, 16'h0010);
    ext_rdy_i = 0;
    for (int i = 0; i < 12; i++) begin
      bus(VECS[i].a, VECS[i].io, hit, n, rel);
      chk(hit == VECS[i].hit, "R3 decode", hit, VECS[i].hit);
      chk(n == int'(VECS[i].n), "R11/R8 rdy timing", n, VECS[i].n);
      chk(rel == 6'h3F, "R10 release", rel, 6'h3F);
    end

    // R6 wait codes for selects 0..3
    for (int c = 0; c < 8; c++) begin
      wr(1'b0, 16'hA940 | 16'(c));
      bus(20'hA9400, 1'b0, hit, n, rel);
      chk(hit == 7'h01, "R6 hit", hit, 1);
      chk(n == LO_W[c], "R6 waits", n, LO_W[c]);
    end

    // R7 waits for selects 5/6
    for (int w = 0; w < 4; w++) begin
      wr(1'b1, 16'(w << 3));
      bus(20'hA9700, 1'b0, hit, n, rel);
      chk(hit == 7'h40, "R7 hit", hit, 7'h40);
      chk(n == w, "R7 waits", n, w);
    end

    // R8 external ready required; R10 address change mid-cycle
    wr(1'b0, 16'hA949);
    ext_rdy_i = 0;
    @(negedge clk_i);
    addr_i = 20'hA9480; io_cyc_i = 0; strobe_i = 1;
    @(posedge clk_i); #1;
    chk(cs_n_o == 4'hD, "R8 select", cs_n_o, 4'hD);
    @(negedge clk_i) addr_i = 20'hA9400;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk_i); #1;
      chk(!rdy_o, "R8 waits for ext", rdy_o, 0);
    end
    chk(cs_n_o == 4'hD, "R10 hold", cs_n_o, 4'hD);
    @(negedge clk_i) ext_rdy_i = 1;
    #1;
    chk(rdy_o, "R8 ext ready", rdy_o, 1);
    @(negedge clk_i) begin strobe_i = 0; ext_rdy_i = 0; end
    @(posedge clk_i); #1;
    chk(cs_n_o == 4'hF, "R10 release", cs_n_o, 4'hF);

    // R4 I/O space for selects 0..3 (reg1 still memory, waits 3)
    wr(1'b0, 16'hA960);
    wr(1'b1, 16'h0018);
    bus(20'h09480, 1'b1, hit, n, rel);
    chk(hit == 7'h02 && n == 0, "R4 io", hit, 7'h02);
    bus(20'hF9480, 1'b1, hit, n, rel);
    chk(hit == 7'h02, "R4 io upper ignored", hit, 7'h02);
    bus(20'hA9480, 1'b0, hit, n, rel);
    chk(hit == 7'h00 && n == NORDY, "R4 mem ignored", hit, 0);
    bus(20'hA9700, 1'b0, hit, n, rel);
    chk(hit == 7'h40 && n == 3, "R5 mem hi group", hit, 7'h40);

    // R5 selects 5/6 in I/O space
    wr(1'b1, 16'h0012);
    bus(20'h09680, 1'b1, hit, n, rel);
    chk(hit == 7'h20 && n == 2, "R5 io", hit, 7'h20);
    bus(20'hA9680, 1'b0, hit, n, rel);
    chk(hit == 7'h00, "R5 mem ignored", hit, 0);

    // R9 address-output mode
    wr(1'b1, 16'h0011);
    @(negedge clk_i) addr_i = 20'hA9684;
    #1;
    chk(cs_a2_o == 1'b1 && cs_a1_o == 1'b0, "R9 addr 4", {cs_a1_o, cs_a2_o}, 2'b01);
    @(negedge clk_i) addr_i = 20'hA9682;
    #1;
    chk(cs_a2_o == 1'b0 && cs_a1_o == 1'b1, "R9 addr 2", {cs_a1_o, cs_a2_o}, 2'b10);
    bus(20'hA9680, 1'b0, hit, n, rel);
    chk((hit & 7'h0F) == 0 && n == NORDY, "R9 no hi select", n, NORDY);
    bus(20'h09480, 1'b1, hit, n, rel);
    chk((hit & 7'h0F) == 7'h02, "R9 lo unaffected", hit & 7'h0F, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule